// File: doc/BRIEF.md
# NAND Flash Address-Encoded Command Sequencer

This block sits between a simple memory-mapped request port and the raw pins of an 8-bit NAND flash device. Each bus access carries its whole flash operation in the address. Bit 19 picks between a command-phase access and a data-phase access. Further address bits carry the command bytes, the number of address cycles, and per-transfer flags for a trailing command and for releasing chip enable. The sequencer plays the resulting byte sequence onto the command latch, address latch, write strobe, read strobe, chip enable and data lines. Strobe widths come from timing parameters.

A command-phase access drives a start command, then up to four address bytes taken from the write data, then an optional trailing command. An operation that needs more than four address cycles is split over two command-phase accesses. The second access carries the upper address bytes and the trailing command.

A data-phase access moves one 32-bit word, either written to the device or read back from it. Chip enable stays low from the first operation until a data-phase access that has its release flag set completes. The requester holds `req_valid` and the request fields until `req_ready` pulses.

Top module: `nand_addr_seq`

## Requirements
- R1: While reset is held low, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1; `nf_cle`, `nf_ale`, `nf_dq_oe` and `req_ready` are 0.
- R2: A command-phase access (address bit 19 = 0) with N = address[23:21] in the range 0 to 4 produces the following bytes, each latched by a write strobe:
  - first, the start command address[10:3], with `nf_cle`=1 and `nf_ale`=0;
  - then N address bytes from `req_wdata`, least significant byte first, with `nf_ale`=1 and `nf_cle`=0;
  - then, when address bit 20 is 1, the trailing command address[18:11], with `nf_cle`=1.
- R3: A command-phase access with N > 4 sends the start command and four address bytes, and no trailing command. The next command-phase access that also has N > 4 sends no start command. It sends N-4 address bytes from its own `req_wdata`, least significant byte first, then the trailing command if its bit 20 is 1.
- R4: A data-phase write (bit 19 = 1, `req_write`=1) sends the four bytes of `req_wdata`, least significant byte first, with `nf_cle`=`nf_ale`=0. When bit 20 is 1, the trailing command address[18:11] follows with `nf_cle`=1.
- R5: A data-phase read gives four read strobes with `nf_dq_oe`=0. Byte k of `rsp_rdata` ([8k+7:8k]) is the value of `nf_dq_i` sampled during the k-th read strobe. A trailing command follows when bit 20 is 1.
- R6: Byte timing is as follows:
  - Each written byte lasts T_WC=2 cycles, with `nf_we_n` low in its first T_WP=1 cycle.
  - Each read byte lasts T_RC=2 cycles, with `nf_re_n` low in its first T_RP=1 cycle.
  - For an operation of K bytes, `req_ready` is high for one cycle, the 2K-th cycle after the acceptance edge.
- R7: `nf_ce_n` goes low with the first byte of any operation. It stays low across operations and returns high in the cycle after the completion of a data-phase access with address bit 21 set. A strobe never occurs while `nf_ce_n` is high.
- R8: Request fields are captured at acceptance. Changes on `req_addr` or `req_wdata` while a sequence runs do not alter the bytes driven. A request waiting at the port is accepted only after the running sequence completes, with one idle cycle between the two.
- R9: In the command phase the direction bit is ignored, so a read access produces the same bytes as a write. In the data phase, address bit 10 has no effect on the bytes, the timing or chip enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 24 | Address that encodes the flash operation |
| req_wdata | input | 32 | Address bytes or data word to write |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Word assembled by the last data-phase read |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_dq_o | output | 8 | Byte driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_o` |
| nf_dq_i | input | 8 | Byte returned by the flash |

## Verification
Two functions meet in a single cycle here:
- the completion of a transfer that releases chip enable;
- the arrival of the next request, which is already waiting on the port in that same cycle.

The bench presents each new request directly after the completion pulse, with no gap. It judges the meeting by checking that `nf_ce_n` is high in the idle cycle between the two operations and that the next operation's bytes begin exactly one cycle later. It also scrambles the request fields in the middle of a sequence, which shows that a waiting or altered request cannot leak into the bytes already under way.

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int T_WC = 2,
  parameter int T_WP = 1,
  parameter int T_RC = 2,
  parameter int T_RP = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic [31:0] rsp_rdata,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic        nf_ce_n,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_i
);
  localparam int TMAX = (T_WC > T_RC) ? T_WC : T_RC;
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] WC_END = CW'(T_WC - 1);
  localparam logic [CW-1:0] RC_END = CW'(T_RC - 1);
  localparam logic [CW-1:0] WP_LEN = CW'(T_WP);
  localparam logic [CW-1:0] RP_LEN = CW'(T_RP);
  localparam logic [CW-1:0] RP_SMP = CW'(T_RP - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DATA, S_ENDC} st_t;

  st_t st, st_nx;
  logic [7:0]    sc_q, ec_q;
  logic [2:0]    na_q;
  logic          endv_q, dph_q, rel_q, wr_q, cont_q, ce_n_q;
  logic [31:0]   d_q, rd_q;
  logic [1:0]    bcnt;
  logic [CW-1:0] tcnt;
  logic          rd_byte, byte_end, fin, go, busy;
  logic [2:0]    n_in;
  logic          unused_bits;

  assign unused_bits = &{1'b0, req_addr[2:0], req_addr[10]};
  assign n_in     = req_addr[23:21];
  assign busy     = st != S_IDLE;
  assign rd_byte  = st == S_DATA && !wr_q;
  assign byte_end = busy && tcnt == (rd_byte ? RC_END : WC_END);
  assign go       = !busy && req_valid;

  always_comb begin
    st_nx = st;
    if (byte_end) begin
      case (st)
        S_CMD:  st_nx = (na_q != 3'd0) ? S_ADDR : (endv_q ? S_ENDC : S_IDLE);
        S_ADDR: if ({1'b0, bcnt} == na_q - 3'd1) st_nx = endv_q ? S_ENDC : S_IDLE;
        S_DATA: if (bcnt == 2'd3) st_nx = endv_q ? S_ENDC : S_IDLE;
        S_ENDC: st_nx = S_IDLE;
        default: st_nx = S_IDLE;
      endcase
    end
  end
  assign fin = byte_end && st_nx == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sc_q <= '0; ec_q <= '0; na_q <= '0;
      endv_q <= 1'b0; dph_q <= 1'b0; rel_q <= 1'b0; wr_q <= 1'b0;
      cont_q <= 1'b0; ce_n_q <= 1'b1;
      d_q <= '0; rd_q <= '0; bcnt <= '0; tcnt <= '0;
    end else if (go) begin
      sc_q   <= req_addr[10:3];
      ec_q   <= req_addr[18:11];
      dph_q  <= req_addr[19];
      rel_q  <= req_addr[21];
      wr_q   <= req_write;
      d_q    <= req_wdata;
      bcnt   <= '0;
      tcnt   <= '0;
      ce_n_q <= 1'b0;
      if (req_addr[19]) begin
        st <= S_DATA; na_q <= '0; endv_q <= req_addr[20];
      end else if (cont_q && n_in > 3'd4) begin
        st <= S_ADDR; na_q <= n_in - 3'd4; endv_q <= req_addr[20]; cont_q <= 1'b0;
      end else begin
        st     <= S_CMD;
        na_q   <= (n_in > 3'd4) ? 3'd4 : n_in;
        endv_q <= req_addr[20] && !(n_in > 3'd4);
        cont_q <= n_in > 3'd4;
      end
    end else if (busy) begin
      if (rd_byte && tcnt == RP_SMP) rd_q[{bcnt, 3'b000} +: 8] <= nf_dq_i;
      if (byte_end) begin
        tcnt <= '0;
        bcnt <= (st_nx != st) ? 2'd0 : bcnt + 2'd1;
        st   <= st_nx;
        if (fin && dph_q && rel_q) ce_n_q <= 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign req_ready = fin;
  assign rsp_rdata = rd_q;
  assign nf_ce_n   = ce_n_q;
  assign nf_cle    = st == S_CMD || st == S_ENDC;
  assign nf_ale    = st == S_ADDR;
  assign nf_dq_oe  = busy && !rd_byte;
  assign nf_we_n   = !(busy && !rd_byte && tcnt < WP_LEN);
  assign nf_re_n   = !(rd_byte && tcnt < RP_LEN);

  always_comb begin
    case (st)
      S_CMD:          nf_dq_o = sc_q;
      S_ENDC:         nf_dq_o = ec_q;
      S_ADDR, S_DATA: nf_dq_o = wr_q || st == S_ADDR ? d_q[{bcnt, 3'b000} +: 8] : 8'h00;
      default:        nf_dq_o = 8'h00;
    endcase
  end
endmodule

module nand_addr_seq_chk #(
  parameter int T_WP = 1
) (
  input logic clk,
  input logic rst_n,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_ce_n,
  input logic nf_dq_oe,
  input logic req_ready
);
  int we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_cnt <= 0;
    else        we_low_cnt <= !nf_we_n ? we_low_cnt + 1 : 0;
  end

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> we_low_cnt < T_WP);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  // R5
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe);

  // R7
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

bind nand_addr_seq nand_addr_seq_chk #(.T_WP(T_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n),
  .nf_dq_oe(nf_dq_oe), .req_ready(req_ready)
);

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_n, nf_dq_oe;
  logic [31:0] rsp_rdata;
  logic [7:0]  nf_dq_o, nf_dq_i;

  nand_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i)
  );

  int checks = 0, failures = 0;
  logic [9:0] logb [0:15];
  logic [9:0] expb [0:15];
  int logn = 0, expn = 0;
  logic [7:0] frd [0:3];
  int rd_idx = 0;
  bit cont_m = 1'b0;

  assign nf_dq_i = frd[rd_idx[1:0]];

  always @(posedge nf_re_n) if (rst_n) rd_idx++;

  always @(negedge clk)
    if (rst_n && !nf_we_n && logn < 16) begin
      logb[logn] = {nf_cle, nf_ale, nf_dq_o};
      logn++;
    end

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic push(bit c, bit a, logic [7:0] d);
    expb[expn] = {c, a, d};
    expn++;
  endtask

  function automatic logic [23:0] cmd_a(logic [2:0] n, bit endv, logic [7:0] ec, logic [7:0] sc);
    return {n, endv, 1'b0, ec, sc, 3'b000};
  endfunction

  function automatic logic [23:0] dat_a(bit rel, bit endv, logic [7:0] ec, bit ecc);
    return {2'b00, rel, endv, 1'b1, ec, ecc, 10'h000};
  endfunction

  task automatic do_op(logic [23:0] a, logic [31:0] d, bit w, bit scr, string r);
    int cyc;
    int k;
    int bad;
    bit rd;
    logic [2:0] n;
    logic ce_exp;
    logn = 0; expn = 0; rd_idx = 0;
    rd = a[19] && !w;
    n = a[23:21];
    if (!a[19]) begin
      if (cont_m && n > 3'd4) begin
        for (int i = 0; i < int'(n) - 4; i++) push(1'b0, 1'b1, d[8*i +: 8]);
        if (a[20]) push(1'b1, 1'b0, a[18:11]);
        cont_m = 1'b0;
      end else begin
        push(1'b1, 1'b0, a[10:3]);
        for (int i = 0; i < ((n > 3'd4) ? 4 : int'(n)); i++) push(1'b0, 1'b1, d[8*i +: 8]);
        if (a[20] && n <= 3'd4) push(1'b1, 1'b0, a[18:11]);
        cont_m = n > 3'd4;
      end
    end else begin
      if (w) for (int i = 0; i < 4; i++) push(1'b0, 1'b0, d[8*i +: 8]);
      if (a[20]) push(1'b1, 1'b0, a[18:11]);
    end
    ce_exp = a[19] && a[21];
    req_addr = a; req_wdata = d; req_write = w; req_valid = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (scr && cyc == 4) begin req_addr = 24'($urandom); req_wdata = $urandom; end
      if (req_ready) break;
      if (cyc > 200) begin chk(1'b0, r, "timeout", cyc, 0); break; end
    end
    if (rd) chk(rsp_rdata == {frd[3], frd[2], frd[1], frd[0]}, "R5", "read word",
                rsp_rdata, {frd[3], frd[2], frd[1], frd[0]});
    @(posedge clk); #1 req_valid = 1'b0;
    k = expn + (rd ? 4 : 0);
    chk(cyc == 2*k + 1, "R6", "cycles to ready", cyc, 2*k + 1);
    bad = -1;
    for (int i = 0; i < expn; i++) if (bad < 0 && (i >= logn || logb[i] !== expb[i])) bad = i;
    if (logn != expn) chk(1'b0, r, "byte count", logn, expn);
    else if (bad >= 0) chk(1'b0, r, "byte {cle,ale,dq}", 32'(logb[bad]), 32'(expb[bad]));
    else chk(1'b1, r, "bytes", 0, 0);
    chk(nf_ce_n == ce_exp, "R7", "chip enable after op", nf_ce_n, ce_exp);
  endtask

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int op;
    logic [2:0] nr;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 4; i++) frd[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(nf_ce_n && nf_we_n && nf_re_n, "R1", "strobes/ce in reset",
        {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    chk(!nf_cle && !nf_ale && !nf_dq_oe && !req_ready, "R1", "latches/oe/ready in reset",
        {nf_cle, nf_ale, nf_dq_oe, req_ready}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    do_op(cmd_a(3'd0, 1'b0, 8'h00, 8'h70), 32'h0, 1'b1, 1'b0, "R2");
    do_op(cmd_a(3'd1, 1'b0, 8'h00, 8'h90), 32'h0000_00a5, 1'b1, 1'b0, "R2");
    do_op(cmd_a(3'd3, 1'b1, 8'hd0, 8'h60), 32'h0012_3456, 1'b1, 1'b0, "R2");
    do_op(cmd_a(3'd5, 1'b1, 8'h30, 8'h00), 32'ha1b2_c3d4, 1'b1, 1'b0, "R3");
    do_op(cmd_a(3'd5, 1'b1, 8'h30, 8'h00), 32'h0000_0007, 1'b1, 1'b0, "R3");
    do_op(cmd_a(3'd7, 1'b1, 8'h30, 8'h00), 32'h0403_0201, 1'b1, 1'b0, "R3");
    do_op(cmd_a(3'd7, 1'b1, 8'h30, 8'h00), 32'h0077_6655, 1'b1, 1'b0, "R3");
    do_op(cmd_a(3'd2, 1'b1, 8'he0, 8'h05), 32'h0000_1234, 1'b0, 1'b0, "R9");
    do_op(dat_a(1'b0, 1'b0, 8'h00, 1'b1), 32'hdead_beef, 1'b1, 1'b0, "R9");
    do_op(dat_a(1'b1, 1'b1, 8'h10, 1'b0), 32'h8899_aabb, 1'b1, 1'b0, "R4");
    do_op(cmd_a(3'd5, 1'b1, 8'h30, 8'h00), 32'h1111_2222, 1'b1, 1'b0, "R7");
    do_op(cmd_a(3'd5, 1'b1, 8'h30, 8'h00), 32'h0000_0003, 1'b1, 1'b0, "R7");
    frd[0] = 8'h3c; frd[1] = 8'hc3; frd[2] = 8'h5a; frd[3] = 8'ha5;
    do_op(dat_a(1'b0, 1'b1, 8'he0, 1'b0), 32'h0, 1'b0, 1'b0, "R5");
    do_op(dat_a(1'b1, 1'b0, 8'h00, 1'b0), 32'h0, 1'b0, 1'b0, "R5");
    do_op(cmd_a(3'd4, 1'b1, 8'h10, 8'h80), 32'hcafe_f00d, 1'b1, 1'b1, "R8");
    do_op(dat_a(1'b1, 1'b1, 8'h10, 1'b1), 32'h0bad_cafe, 1'b1, 1'b1, "R8");

    for (int it = 0; it < 60; it++) begin
      op = int'($urandom_range(0, 2));
      for (int i = 0; i < 4; i++) frd[i] = 8'($urandom);
      nr = 3'($urandom);
      if (op == 0)
        do_op(cmd_a(nr, 1'($urandom), 8'($urandom), 8'($urandom)), $urandom,
              1'($urandom), 1'($urandom), nr > 3'd4 ? "R3" : "R2");
      else if (op == 1)
        do_op(dat_a(1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom)), $urandom,
              1'b1, 1'($urandom), "R4");
      else
        do_op(dat_a(1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom)), $urandom,
              1'b0, 1'($urandom), "R5");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule